// File: doc/BRIEF.md
# Two-Stage Pipelined Wide Magnitude Comparator

This block compares two 64-bit unsigned operands and reports whether the first is greater than, less than or equal to the second. It accepts a new operand pair on every clock and delivers each verdict a fixed two cycles later. An input valid flag travels down the pipeline beside the data.

The first stage splits each operand into eight 8-bit groups. A dedicated 8-bit comparator handles each group and gives a greater/less pair for it, and the eight pairs are registered. The second stage reuses the same 8-bit comparator. It takes the group "greater" flags as one operand and the group "less" flags as the other, with the top group as the most significant bit. Each 8-bit comparator is two 4-bit priority slices. The lower slice is enabled only when the upper slice finds its bits equal, so the most significant unequal bit decides. Both stages therefore have the depth of one 8-bit comparison. The dynamic-logic half-cycle latching of a full-custom version is modelled here as ordinary edge-triggered registers.

Top module: `wcmp_pipe`

## Requirements
- R1: While and directly after a synchronous active-low reset, out_valid, out_gt, out_lt and out_eq are all 0.
- R2: For a valid input pair, out_gt is 1 exactly when in_a is greater than in_b as unsigned numbers.
- R3: For a valid input pair, out_lt is 1 exactly when in_a is less than in_b as unsigned numbers.
- R4: For a valid input pair, out_eq is 1 exactly when in_a equals in_b.
- R5: Whenever out_valid is 1, exactly one of out_gt, out_lt and out_eq is 1.
- R6: out_valid after a rising edge equals the in_valid that was sampled two rising edges earlier. Pairs offered on consecutive cycles each produce their own result, in order.
- R7: Operand pairs that differ only in bit 0 are resolved correctly in both directions.
- R8: The most significant differing 8-bit group decides the result, even when every lower group differs in the opposite direction.
- R9: Inside a group, a difference in bits 7..4 decides the result, even when bits 3..0 differ in the opposite direction.
- R10: When out_valid is 0, out_gt, out_lt and out_eq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on in_a/in_b is to be compared |
| in_a | input | 64 | First operand, unsigned |
| in_b | input | 64 | Second operand, unsigned |
| out_valid | output | 1 | Result flags carry a verdict |
| out_gt | output | 1 | in_a was greater than in_b |
| out_lt | output | 1 | in_a was less than in_b |
| out_eq | output | 1 | in_a was equal to in_b |

## Verification
Every cycle, stage two resolves one operand pair while stage one already evaluates the next. The bench provokes this with back-to-back streams whose neighbouring pairs have opposite verdicts, for example greater followed by less or equal. Each output cycle is then judged against a bench-side queue of expected flags, so a result that leaks from one pair into its neighbour, or slips by a cycle, shows up as a mismatch. Gaps in in_valid are mixed into the stream so that idle cycles are seen next to live ones.

// File: rtl/wcmp_pkg.sv
// Package: shared types for the pipelined wide comparator.
// Assumes nothing beyond a two-flag verdict per compared field.
package wcmp_pkg;

    // Verdict of one field comparison: first operand greater / less.
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_pair_t;

endpackage

// File: rtl/wcmp_slice.sv
// Module: wcmp_slice
// Priority slice: finds the most significant unequal bit of a and b and
// reports which operand holds the 1 there. Outputs are forced low when
// en is 0 (a more significant slice already decided). eq reports that
// the slice's own bits are all equal, regardless of en.
module wcmp_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               en,
    output logic               gt,
    output logic               lt,
    output logic               eq
);

    logic [SLICE_W-1:0] diff;
    logic [SLICE_W-1:0] hit;
    logic               found;

    // Locate the top differing bit as a one-hot mask.
    always_comb begin
        diff  = a ^ b;
        hit   = '0;
        found = 1'b0;
        for (int i = SLICE_W - 1; i >= 0; i--) begin
            if (diff[i] && !found) begin
                hit[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Attribute the winning bit to its operand, gated by the enable.
    always_comb begin
        gt = en & (|(hit & a));
        lt = en & (|(hit & b));
        eq = ~found;
    end

endmodule

// File: rtl/wcmp_macro.sv
// Module: wcmp_macro
// W-bit magnitude comparator built from W/SLICE_W priority slices.
// The top slice is always enabled. Each lower slice is enabled only when
// every slice above it is equal (look-ahead chain). The macro has no
// look-ahead output because macros are never chained to each other.
// Assumes W is a multiple of SLICE_W.
module wcmp_macro
    import wcmp_pkg::*;
#(
    parameter int W       = 8,
    parameter int SLICE_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_pair_t    res
);

    localparam int N_SL = W / SLICE_W;

    logic [N_SL-1:0] s_gt;
    logic [N_SL-1:0] s_lt;
    logic [N_SL-1:0] s_eq;
    logic [N_SL-1:0] s_en;

    for (genvar k = 0; k < N_SL; k++) begin : g_slice
        if (k == N_SL - 1) begin : g_top
            // Top slice: nothing above it, always enabled.
            assign s_en[k] = 1'b1;
        end else begin : g_low
            // Lower slice: enabled when everything above is equal.
            assign s_en[k] = s_en[k+1] & s_eq[k+1];
        end

        wcmp_slice #(.SLICE_W(SLICE_W)) slice_i (
            .a  (a[k*SLICE_W +: SLICE_W]),
            .b  (b[k*SLICE_W +: SLICE_W]),
            .en (s_en[k]),
            .gt (s_gt[k]),
            .lt (s_lt[k]),
            .eq (s_eq[k])
        );
    end

    // At most one slice is enabled with a difference; merge by OR.
    always_comb begin
        res.gt = |s_gt;
        res.lt = |s_lt;
    end

endmodule

// File: rtl/wcmp_pipe.sv
// Module: wcmp_pipe (top)
// Two-stage unsigned magnitude comparator. Stage one compares N_GROUPS
// groups of GROUP_W bits in parallel and registers per-group verdicts.
// Stage two feeds those verdicts (gt as operand a, lt as operand b, top
// group most significant) into the same macro and registers the final
// flags. Latency is two cycles, throughput one pair per cycle.
// Assumes N_GROUPS and GROUP_W are multiples of SLICE_W.
module wcmp_pipe
    import wcmp_pkg::*;
#(
    parameter int GROUP_W  = 8,
    parameter int N_GROUPS = 8,
    parameter int SLICE_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [GROUP_W*N_GROUPS-1:0]  in_a,
    input  logic [GROUP_W*N_GROUPS-1:0]  in_b,
    output logic                         out_valid,
    output logic                         out_gt,
    output logic                         out_lt,
    output logic                         out_eq
);

    localparam int WIDTH = GROUP_W * N_GROUPS;

    cmp_pair_t           grp_res [N_GROUPS];
    logic [N_GROUPS-1:0] grp_gt_d;
    logic [N_GROUPS-1:0] grp_lt_d;
    logic [N_GROUPS-1:0] s1_gt;
    logic [N_GROUPS-1:0] s1_lt;
    logic                s1_valid;
    cmp_pair_t           fin_res;

    // Stage one: one macro per group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        wcmp_macro #(.W(GROUP_W), .SLICE_W(SLICE_W)) grp_i (
            .a   (in_a[g*GROUP_W +: GROUP_W]),
            .b   (in_b[g*GROUP_W +: GROUP_W]),
            .res (grp_res[g])
        );
        assign grp_gt_d[g] = grp_res[g].gt;
        assign grp_lt_d[g] = grp_res[g].lt;
    end

    // Register the per-group verdicts between the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_gt    <= '0;
            s1_lt    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_gt    <= grp_gt_d;
            s1_lt    <= grp_lt_d;
        end
    end

    // Stage two: same macro over the group verdict vectors.
    wcmp_macro #(.W(N_GROUPS), .SLICE_W(SLICE_W)) fin_i (
        .a   (s1_gt),
        .b   (s1_lt),
        .res (fin_res)
    );

    // Register the final flags; all flags low on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_gt    <= 1'b0;
            out_lt    <= 1'b0;
            out_eq    <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_gt    <= s1_valid & fin_res.gt;
            out_lt    <= s1_valid & fin_res.lt;
            out_eq    <= s1_valid & ~(|(s1_gt | s1_lt));
        end
    end

endmodule

// File: rtl/wcmp_pipe_chk.sv
// Module: wcmp_pipe_chk
// Property checker for wcmp_pipe, attached by bind. Observes ports only.
module wcmp_pipe_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_valid,
    input logic             out_gt,
    input logic             out_lt,
    input logic             out_eq
);

    // R5
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_gt, out_lt, out_eq}) == 1));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_gt || out_lt || out_eq));

    // R6
    valid_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R6
    valid_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R2
    greater_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a > in_b)) |-> ##2 out_gt);

    // R3
    less_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a < in_b)) |-> ##2 out_lt);

    // R4
    equal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a == in_b)) |-> ##2 out_eq);

endmodule

bind wcmp_pipe wcmp_pipe_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_gt    (out_gt),
    .out_lt    (out_lt),
    .out_eq    (out_eq)
);

// File: tb/wcmp_pipe_tb_top.sv
// Directed bench for wcmp_pipe. Inputs change and outputs are sampled on
// the falling edge. Expected flags ride in a queue two slots deep.
module wcmp_pipe_tb_top;

    localparam int W = 64;

    typedef struct {
        logic       v;
        logic       gt;
        logic       lt;
        logic       eq;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic         out_gt;
    logic         out_lt;
    logic         out_eq;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t pipe_q[$];

    always #5 clk = ~clk;

    wcmp_pipe dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_gt    (out_gt),
        .out_lt    (out_lt),
        .out_eq    (out_eq)
    );

    // Compare one observed bit against its expected value.
    task automatic check_bit(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    // Check the outputs against the oldest of two queued expectations.
    task automatic check_head();
        exp_t e;
        if (pipe_q.size() < 2) return;
        e = pipe_q.pop_front();
        check_bit(e.tag, "valid R6", out_valid, e.v);
        if (e.v) begin
            check_bit(e.tag, "gt R2", out_gt, e.gt);
            check_bit(e.tag, "lt R3", out_lt, e.lt);
            check_bit(e.tag, "eq R4", out_eq, e.eq);
            check_bit(e.tag, "one-hot R5",
                      $countones({out_gt, out_lt, out_eq}) == 1, 1'b1);
        end else begin
            check_bit(e.tag, "idle flags R10", out_gt | out_lt | out_eq, 1'b0);
        end
    endtask

    // One cycle: check matured result, then present the next input.
    task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b, string tag);
        exp_t e;
        @(negedge clk);
        check_head();
        e.v   = v;
        e.gt  = v && (a > b);
        e.lt  = v && (a < b);
        e.eq  = v && (a == b);
        e.tag = tag;
        pipe_q.push_back(e);
        in_valid = v;
        in_a     = a;
        in_b     = b;
    endtask

    // Drain the pipeline with idle cycles.
    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, '0, '0, "flush");
    endtask

    // R1: outputs low during and right after reset.
    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_a     = 64'hFFFF_0000_FFFF_0000;
        in_b     = '0;
        repeat (3) @(negedge clk);
        check_bit("R1", "valid in reset", out_valid, 1'b0);
        check_bit("R1", "flags in reset", out_gt | out_lt | out_eq, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", "valid after reset", out_valid, 1'b0);
        check_bit("R1", "flags after reset", out_gt | out_lt | out_eq, 1'b0);
        pipe_q.delete();
        pipe_q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, "R1"});
        pipe_q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, "R1"});
    endtask

    // R7: pairs differing only in bit 0, both ways, back to back.
    task automatic t_lsb_only();
        logic [W-1:0] base = 64'hA5C3_9E01_7F80_3C5A;
        step(1'b1, base | 64'd1, base & ~64'd1, "R7 a>b");
        step(1'b1, base & ~64'd1, base | 64'd1, "R7 a<b");
        step(1'b1, base | 64'd1, base | 64'd1, "R7 equal");
        step(1'b1, 64'd1, 64'd0, "R7 small");
        flush();
    endtask

    // R8: top differing group wins over opposite lower groups.
    task automatic t_group_priority();
        step(1'b1, 64'h0100_0000_0000_0000, 64'h00FF_FFFF_FFFF_FFFF, "R8 g7 gt");
        step(1'b1, 64'h0000_0000_0000_FFFF, 64'h0000_0001_0000_0000, "R8 g4 lt");
        step(1'b1, 64'h1234_0000_0000_0100, 64'h1234_0000_0000_00FF, "R8 g1 gt");
        flush();
    endtask

    // R9: upper half of a group wins over opposite lower half.
    task automatic t_slice_priority();
        step(1'b1, 64'h0000_0000_1000_0000, 64'h0000_0000_0F00_0000, "R9 hi nibble gt");
        step(1'b1, 64'h0000_0000_0000_000F, 64'h0000_0000_0000_0010, "R9 g0 lt");
        step(1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R9 msb");
        flush();
    endtask

    // R4: equal operands of several shapes.
    task automatic t_equal();
        step(1'b1, '0, '0, "R4 zero");
        step(1'b1, '1, '1, "R4 ones");
        step(1'b1, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, "R4 mixed");
        flush();
    endtask

    // R2 R3 R6: back-to-back random pairs, some sharing upper bits.
    task automatic t_stream();
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = {$urandom(), $urandom()};
            case (i % 3)
                0: b = {$urandom(), $urandom()};
                1: b = a ^ (64'd1 << ($urandom() % 64));
                default: b = a;
            endcase
            step(1'b1, a, b, "R2/R3 stream");
        end
        flush();
    endtask

    // R6 R10: valid with gaps, opposite verdicts next to idle cycles.
    task automatic t_gaps();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a;
            a = {$urandom(), $urandom()};
            step(i[0], a, ~a, "R6 gaps");
        end
        flush();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lsb_only();
        t_group_priority();
        t_slice_priority();
        t_equal();
        t_stream();
        t_gaps();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule